// File: doc/BRIEF.md
# AXI4 Sequential Bandwidth Meter

This block is an AXI4 master that measures how fast a memory slave can sink and then source a long, purely sequential stream. One start pulse launches a run over a region given as a base address and a number of 4 KiB bursts. The block first writes the whole region with back-to-back bursts, keeping as many bursts in flight as the outstanding limit allows. Once every write response has returned, it reads the same region back the same way.

For each of the two phases it reports a raw clock-cycle count. Turning that count into bytes per second is left to whoever reads the result, so no clock frequency is built into the hardware. The written data is a pattern derived from the address. The read phase checks the returned data against that same pattern. Any non-OKAY response, or any read-data mismatch, raises a sticky error flag.

With the default widths, the burst count covers up to 65536 bursts. That is a 256 MiB region, which is the usual measurement size.

Top module: `memsweep_top`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `err`, `awvalid`, `wvalid` and `arvalid` are low, and both cycle counts are zero.
- R2: A start pulse in idle with N > 0 bursts issues N write bursts at increasing addresses base + k·4096, for k = 0..N-1. It then issues N read bursts at the same addresses. Every burst has len 127, size 5 (32 bytes per beat) and burst type INCR (2'b01).
- R3: No more than 16 bursts are outstanding in each direction. A write burst is outstanding from its AW handshake until its B handshake. A read burst is outstanding from its AR handshake until its RLAST handshake.
- R4: No read address is issued until the write response of every write burst has been received.
- R5: Beat j of the write burst at address A carries the value A + 32·j + 4·i in 32-bit lane i (bits 32i+31..32i). `wstrb` is all ones, and `wlast` is high on beat 127 only. No data is sent for a burst before its address has been accepted.
- R6: `wr_cycles` equals the cycle of the last B handshake minus the cycle of the first AW handshake, plus one. `rd_cycles` is formed the same way from the first AR handshake and the last RLAST handshake. Both hold until the next accepted start.
- R7: `busy` is high from the cycle after an accepted start until the last RLAST handshake. `done` goes high in the cycle after that handshake and stays high until the next accepted start.
- R8: `err` goes high in the cycle after any B or R handshake whose response code is not 2'b00 (OKAY). The run still completes. `err` is cleared by the next accepted start.
- R9: A start pulse while `busy` is high is ignored. The running phase, its addresses and its burst total are unchanged.
- R10: A start with N = 0 issues no request, leaves `busy` low, sets `done` in the next cycle and clears both counts to zero.
- R11: The low 12 bits of the base address are ignored: the region starts at the base rounded down to a 4 KiB boundary. No burst crosses a 4 KiB boundary.
- R12: `bready` and `rready` are held high, so a response is accepted in the cycle it is presented.
- R13: An R beat whose data differs from the R5 pattern for that beat's address sets `err`, with the same timing as R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle run request |
| base_addr | input | 32 | Region base address, rounded down to 4 KiB |
| num_bursts | input | 17 | Region length in 4 KiB bursts |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has finished |
| err | output | 1 | A bad response or bad read data was seen in this run |
| wr_cycles | output | 40 | Raw cycle count of the write phase |
| rd_cycles | output | 40 | Raw cycle count of the read phase |
| awaddr | output | 32 | Write address |
| awlen | output | 8 | Write burst length minus one |
| awsize | output | 3 | Write beat size code |
| awburst | output | 2 | Write burst type |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| wdata | output | 256 | Write data |
| wstrb | output | 32 | Write byte strobes |
| wlast | output | 1 | Final beat of a write burst |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| bresp | input | 2 | Write response code |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready |
| araddr | output | 32 | Read address |
| arlen | output | 8 | Read burst length minus one |
| arsize | output | 3 | Read beat size code |
| arburst | output | 2 | Read burst type |
| arvalid | output | 1 | Read address valid |
| arready | input | 1 | Read address ready |
| rdata | input | 256 | Read data |
| rresp | input | 2 | Read response code |
| rlast | input | 1 | Final beat of a read burst |
| rvalid | input | 1 | Read data valid |
| rready | output | 1 | Read data ready |

## Verification
The embedded properties assume a well-behaved slave. It returns one write response per accepted write burst and one RLAST per accepted read burst. It never answers a burst that has not been addressed, and it never sends read data before the read phase. The bench's slave model keeps to this by queueing every accepted burst and answering strictly from the head of its queues, after a programmable latency. It inserts random ready and valid stalls only where the protocol permits them, and it asserts RLAST exactly on the 128th beat. Error responses and corrupted read data are injected only on bursts that the block has actually issued, so every injected fault corresponds to a real handshake.

// File: rtl/memsweep_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the sequential bandwidth meter.
package memsweep_pkg;
    // Run phase: idle, write sweep, read sweep.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WRITE = 2'd1,
        PH_READ  = 2'd2
    } phase_e;

    localparam logic [1:0] RESP_OKAY  = 2'b00;
    localparam logic [1:0] BURST_INCR = 2'b01;
endpackage

// File: rtl/memsweep_pattern.sv
`timescale 1ns/1ps
// Address-derived data word: 32-bit lane i holds beat_addr + 4*i.
// Assumes DATA_W is a multiple of 32. Purely combinational.
module memsweep_pattern #(
    parameter int DATA_W = 256
) (
    input  logic [31:0]       beat_addr,
    output logic [DATA_W-1:0] word
);
    localparam int LANES = DATA_W / 32;

    // One adder per 32-bit lane.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign word[i*32 +: 32] = beat_addr + 32'(4 * i);
    end
endmodule

// File: rtl/memsweep_span_timer.sv
`timescale 1ns/1ps
// Inclusive cycle counter: loads 1 on the opening event and counts every
// cycle up to and including the closing event, then holds.
// Assumes the open and close events never fall in the same cycle.
module memsweep_span_timer #(
    parameter int CNT_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             open_evt,
    input  logic             close_evt,
    output logic [CNT_W-1:0] span
);
    logic running_q;

    // Count the window between the open and close events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            span      <= '0;
            running_q <= 1'b0;
        end else if (clear) begin
            span      <= '0;
            running_q <= 1'b0;
        end else if (open_evt) begin
            span      <= CNT_W'(1);
            running_q <= 1'b1;
        end else if (running_q) begin
            span <= span + 1'b1;
            if (close_evt) running_q <= 1'b0;
        end
    end

    // R6: the phase can only end after it has begun.
    a_r6_close_after_open: assert property (@(posedge clk) disable iff (!rst_n)
        close_evt |-> running_q);
endmodule

// File: rtl/memsweep_addr_issue.sv
`timescale 1ns/1ps
// Address channel sequencer for one direction. Issues `total` bursts at
// consecutive BURST_BYTES steps from `base`, keeps at most MAX_OUT
// outstanding, and retires one burst per `retire` pulse.
// Assumes `base` is burst aligned and `retire` only follows an issued burst.
module memsweep_addr_issue #(
    parameter int ADDR_W      = 32,
    parameter int NB_W        = 17,
    parameter int MAX_OUT     = 16,
    parameter int BURST_BYTES = 4096,
    localparam int OUT_W      = $clog2(MAX_OUT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              enable,
    input  logic [ADDR_W-1:0] base,
    input  logic [NB_W-1:0]   total,
    input  logic              a_ready,
    input  logic              retire,
    output logic              a_valid,
    output logic [ADDR_W-1:0] a_addr,
    output logic [NB_W-1:0]   issued,
    output logic [OUT_W-1:0]  in_flight,
    output logic              first_hs,
    output logic              last_retire
);
    logic [NB_W-1:0]   issued_q;
    logic [NB_W-1:0]   retired_q;
    logic [OUT_W-1:0]  inflight_q;
    logic [ADDR_W-1:0] addr_q;
    logic              hs;

    // Request while bursts remain and the in-flight window has room.
    assign a_valid     = enable && (issued_q < total) && (inflight_q < OUT_W'(MAX_OUT));
    assign hs          = a_valid && a_ready;
    assign first_hs    = hs && (issued_q == '0);
    assign last_retire = retire && (retired_q == total - NB_W'(1));
    assign a_addr      = addr_q;
    assign issued      = issued_q;
    assign in_flight   = inflight_q;

    // Track issued/retired totals, the in-flight window and the next address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issued_q   <= '0;
            retired_q  <= '0;
            inflight_q <= '0;
            addr_q     <= '0;
        end else if (clear) begin
            issued_q   <= '0;
            retired_q  <= '0;
            inflight_q <= '0;
            addr_q     <= base;
        end else begin
            if (hs) begin
                issued_q <= issued_q + 1'b1;
                addr_q   <= addr_q + ADDR_W'(BURST_BYTES);
            end
            if (retire) retired_q <= retired_q + 1'b1;
            case ({hs, retire})
                2'b10:   inflight_q <= inflight_q + 1'b1;
                2'b01:   inflight_q <= inflight_q - 1'b1;
                default: inflight_q <= inflight_q;
            endcase
        end
    end

    // R2: a pending request keeps its address until accepted.
    a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        a_valid && !a_ready |=> a_valid && $stable(a_addr));
    // R3: the window never exceeds the limit.
    a_r3_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
        inflight_q <= OUT_W'(MAX_OUT));
    // R3: a response only arrives for a burst that is outstanding.
    a_r3_retire_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        retire |-> inflight_q != '0);
    // R11: every request starts on a burst boundary.
    a_r11_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        a_valid |-> (a_addr & ADDR_W'(BURST_BYTES - 1)) == '0);
endmodule

// File: rtl/memsweep_wbeat.sv
`timescale 1ns/1ps
// Write data sequencer. Streams BEATS beats per burst for every burst whose
// address has been accepted, with the address pattern as payload.
// Assumes BEATS is a power of two and ADDR_W is at least 32.
module memsweep_wbeat #(
    parameter int DATA_W = 256,
    parameter int ADDR_W = 32,
    parameter int NB_W   = 17,
    parameter int BEATS  = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic [ADDR_W-1:0]   base,
    input  logic [NB_W-1:0]     granted,
    input  logic                w_ready,
    output logic                w_valid,
    output logic [DATA_W-1:0]   w_data,
    output logic [DATA_W/8-1:0] w_strb,
    output logic                w_last
);
    localparam int BEAT_W     = $clog2(BEATS);
    localparam int BEAT_BYTES = DATA_W / 8;

    logic [NB_W-1:0]   sent_q;
    logic [BEAT_W-1:0] beat_q;
    logic [ADDR_W-1:0] baddr_q;

    assign w_valid = sent_q < granted;
    assign w_last  = beat_q == BEAT_W'(BEATS - 1);
    assign w_strb  = '1;

    memsweep_pattern #(.DATA_W(DATA_W)) u_pat (
        .beat_addr (32'(baddr_q)),
        .word      (w_data)
    );

    // Advance beat, burst and beat address on each accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sent_q  <= '0;
            beat_q  <= '0;
            baddr_q <= '0;
        end else if (clear) begin
            sent_q  <= '0;
            beat_q  <= '0;
            baddr_q <= base;
        end else if (w_valid && w_ready) begin
            baddr_q <= baddr_q + ADDR_W'(BEAT_BYTES);
            beat_q  <= beat_q + 1'b1;
            if (w_last) sent_q <= sent_q + 1'b1;
        end
    end

    // R5: a stalled beat keeps its payload and last marker.
    a_r5_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        w_valid && !w_ready |=> w_valid && $stable(w_data) && $stable(w_last));
endmodule

// File: rtl/memsweep_top.sv
`timescale 1ns/1ps
// Sequential bandwidth meter: one start pulse writes N 4 KiB bursts from a
// base address, then reads them back, and reports each phase's raw cycle
// count. Assumes an AXI4 slave that answers every accepted burst exactly once.
module memsweep_top
    import memsweep_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 256,
    parameter int NB_W    = 17,
    parameter int CNT_W   = 40,
    parameter int MAX_OUT = 16,
    parameter int BEATS   = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [ADDR_W-1:0]   base_addr,
    input  logic [NB_W-1:0]     num_bursts,
    output logic                busy,
    output logic                done,
    output logic                err,
    output logic [CNT_W-1:0]    wr_cycles,
    output logic [CNT_W-1:0]    rd_cycles,
    output logic [ADDR_W-1:0]   awaddr,
    output logic [7:0]          awlen,
    output logic [2:0]          awsize,
    output logic [1:0]          awburst,
    output logic                awvalid,
    input  logic                awready,
    output logic [DATA_W-1:0]   wdata,
    output logic [DATA_W/8-1:0] wstrb,
    output logic                wlast,
    output logic                wvalid,
    input  logic                wready,
    input  logic [1:0]          bresp,
    input  logic                bvalid,
    output logic                bready,
    output logic [ADDR_W-1:0]   araddr,
    output logic [7:0]          arlen,
    output logic [2:0]          arsize,
    output logic [1:0]          arburst,
    output logic                arvalid,
    input  logic                arready,
    input  logic [DATA_W-1:0]   rdata,
    input  logic [1:0]          rresp,
    input  logic                rlast,
    input  logic                rvalid,
    output logic                rready
);
    localparam int BEAT_BYTES  = DATA_W / 8;
    localparam int BURST_BYTES = BEAT_BYTES * BEATS;
    localparam int OUT_W       = $clog2(MAX_OUT + 1);

    phase_e            phase_q;
    logic [NB_W-1:0]   total_q;
    logic [ADDR_W-1:0] base_aligned;
    logic [ADDR_W-1:0] rbaddr_q;
    logic [DATA_W-1:0] rd_expect;
    logic              start_ok, b_hs, r_hs, b_bad, r_bad;
    logic              wr_first, wr_last, rd_first, rd_last;
    logic [NB_W-1:0]   wr_issued, rd_issued;
    logic [OUT_W-1:0]  wr_inflight, rd_inflight;

    assign start_ok     = start && (phase_q == PH_IDLE);
    assign base_aligned = base_addr & ~ADDR_W'(BURST_BYTES - 1);
    assign busy         = phase_q != PH_IDLE;
    assign bready       = 1'b1;
    assign rready       = 1'b1;
    assign b_hs         = bvalid && bready;
    assign r_hs         = rvalid && rready;
    assign b_bad        = b_hs && (bresp != RESP_OKAY);
    assign r_bad        = r_hs && ((rresp != RESP_OKAY) || (rdata != rd_expect));

    assign awlen   = 8'(BEATS - 1);
    assign arlen   = 8'(BEATS - 1);
    assign awsize  = 3'($clog2(BEAT_BYTES));
    assign arsize  = 3'($clog2(BEAT_BYTES));
    assign awburst = BURST_INCR;
    assign arburst = BURST_INCR;

    memsweep_addr_issue #(
        .ADDR_W(ADDR_W), .NB_W(NB_W), .MAX_OUT(MAX_OUT), .BURST_BYTES(BURST_BYTES)
    ) u_wr_issue (
        .clk(clk), .rst_n(rst_n), .clear(start_ok), .enable(phase_q == PH_WRITE),
        .base(base_aligned), .total(total_q), .a_ready(awready), .retire(b_hs),
        .a_valid(awvalid), .a_addr(awaddr), .issued(wr_issued),
        .in_flight(wr_inflight), .first_hs(wr_first), .last_retire(wr_last)
    );

    memsweep_addr_issue #(
        .ADDR_W(ADDR_W), .NB_W(NB_W), .MAX_OUT(MAX_OUT), .BURST_BYTES(BURST_BYTES)
    ) u_rd_issue (
        .clk(clk), .rst_n(rst_n), .clear(start_ok), .enable(phase_q == PH_READ),
        .base(base_aligned), .total(total_q), .a_ready(arready), .retire(r_hs && rlast),
        .a_valid(arvalid), .a_addr(araddr), .issued(rd_issued),
        .in_flight(rd_inflight), .first_hs(rd_first), .last_retire(rd_last)
    );

    memsweep_wbeat #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NB_W(NB_W), .BEATS(BEATS)
    ) u_wbeat (
        .clk(clk), .rst_n(rst_n), .clear(start_ok), .base(base_aligned),
        .granted(wr_issued), .w_ready(wready), .w_valid(wvalid),
        .w_data(wdata), .w_strb(wstrb), .w_last(wlast)
    );

    memsweep_pattern #(.DATA_W(DATA_W)) u_rd_pat (
        .beat_addr (32'(rbaddr_q)),
        .word      (rd_expect)
    );

    memsweep_span_timer #(.CNT_W(CNT_W)) u_wr_timer (
        .clk(clk), .rst_n(rst_n), .clear(start_ok),
        .open_evt(wr_first), .close_evt(wr_last), .span(wr_cycles)
    );

    memsweep_span_timer #(.CNT_W(CNT_W)) u_rd_timer (
        .clk(clk), .rst_n(rst_n), .clear(start_ok),
        .open_evt(rd_first), .close_evt(rd_last), .span(rd_cycles)
    );

    // Address of the next expected read beat for the data check.
    always_ff @(posedge clk) begin
        if (!rst_n)        rbaddr_q <= '0;
        else if (start_ok) rbaddr_q <= base_aligned;
        else if (r_hs)     rbaddr_q <= rbaddr_q + ADDR_W'(BEAT_BYTES);
    end

    // Run sequencing, completion flag and sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            total_q <= '0;
            done    <= 1'b0;
            err     <= 1'b0;
        end else if (start_ok) begin
            total_q <= num_bursts;
            done    <= (num_bursts == '0);
            err     <= 1'b0;
            phase_q <= (num_bursts == '0) ? PH_IDLE : PH_WRITE;
        end else begin
            case (phase_q)
                PH_WRITE: if (wr_last) phase_q <= PH_READ;
                PH_READ:  if (rd_last) begin
                              phase_q <= PH_IDLE;
                              done    <= 1'b1;
                          end
                default:  phase_q <= phase_q;
            endcase
            if (b_bad || r_bad) err <= 1'b1;
        end
    end

    // R4: reads wait for every write response.
    a_r4_reads_after_writes: assert property (@(posedge clk) disable iff (!rst_n)
        arvalid |-> (wr_inflight == '0) && (wr_issued == total_q));
    // R2: the read sweep never runs past the region.
    a_r2_read_count: assert property (@(posedge clk) disable iff (!rst_n)
        rd_issued <= total_q);
    // R3: the read window stays within the limit.
    a_r3_read_window: assert property (@(posedge clk) disable iff (!rst_n)
        rd_inflight <= OUT_W'(MAX_OUT));
    // R8: the error flag holds until a new start.
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err && !start |=> err);
    // R7: completion and activity are exclusive.
    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R10: an empty run completes at once.
    a_r10_empty_run: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok && (num_bursts == '0) |=> done && !busy);
endmodule

// File: tb/test_memsweep_top.sv
`timescale 1ns/1ps
// Bench: behavioural AXI4 slave with random stalls plus a queue-based
// reference model of the run, compared on every clock.
module test_memsweep_top;
    localparam int ADDR_W = 32, DATA_W = 256, NB_W = 17, CNT_W = 40;

    logic clk = 1'b0;
    always #4 clk = ~clk;  // 125 MHz

    logic rst_n, start;
    logic [ADDR_W-1:0] base_addr;
    logic [NB_W-1:0] num_bursts;
    logic busy, done, err;
    logic [CNT_W-1:0] wr_cycles, rd_cycles;
    logic [ADDR_W-1:0] awaddr, araddr;
    logic [7:0] awlen, arlen;
    logic [2:0] awsize, arsize;
    logic [1:0] awburst, arburst, bresp, rresp;
    logic awvalid, awready, wlast, wvalid, wready, bvalid, bready;
    logic arvalid, arready, rlast, rvalid, rready;
    logic [DATA_W-1:0] wdata, rdata;
    logic [DATA_W/8-1:0] wstrb;

    memsweep_top i_memsweep_top (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .num_bursts(num_bursts), .busy(busy), .done(done), .err(err),
        .wr_cycles(wr_cycles), .rd_cycles(rd_cycles),
        .awaddr(awaddr), .awlen(awlen), .awsize(awsize), .awburst(awburst),
        .awvalid(awvalid), .awready(awready), .wdata(wdata), .wstrb(wstrb),
        .wlast(wlast), .wvalid(wvalid), .wready(wready), .bresp(bresp),
        .bvalid(bvalid), .bready(bready), .araddr(araddr), .arlen(arlen),
        .arsize(arsize), .arburst(arburst), .arvalid(arvalid), .arready(arready),
        .rdata(rdata), .rresp(rresp), .rlast(rlast), .rvalid(rvalid), .rready(rready)
    );

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    // Stimulus knobs and fault injection.
    int rdy_pct = 100, lat = 2, berr_at = -1, rerr_at = -1, dbad_at = -1;
    bit start_req = 0;

    // Reference model state.
    bit m_busy = 0, m_done = 0, m_err = 0;
    logic [31:0] m_base = 0;
    int m_num = 0;
    int cyc = 0;
    int n_aw, n_ar, n_wbeats, n_wlast, n_b, n_rlast, w_out, r_out, max_w, max_r;
    int first_aw, last_b, first_ar, last_r, w_beat, r_beat;
    logic [31:0] aw_q[$];
    logic [31:0] r_addr_q[$];
    int b_due[$], r_due[$];
    logic [1:0] b_resp_q[$];

    task automatic check(input bit ok, input string req,
                         input logic [255:0] act, input logic [255:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [255:0] pat(input logic [31:0] a);
        logic [255:0] v;
        for (int i = 0; i < 8; i++) v[i*32 +: 32] = a + 32'(4 * i);
        return v;
    endfunction

    // Slave model and per-clock comparison, evaluated at each falling edge.
    initial begin
        start = 0; awready = 0; wready = 0; arready = 0; bvalid = 0; bresp = 0;
        rvalid = 0; rlast = 0; rresp = 0; rdata = '0;
        forever begin
            @(negedge clk);
            start = start_req;
            start_req = 0;
            awready = ($urandom_range(0, 99) < rdy_pct);
            wready  = ($urandom_range(0, 99) < rdy_pct);
            arready = ($urandom_range(0, 99) < rdy_pct);
            bvalid = (b_due.size() != 0) && (b_due[0] <= cyc);
            bresp  = bvalid ? b_resp_q[0] : 2'b00;
            rvalid = 0; rlast = 0; rresp = 0; rdata = '0;
            if (r_due.size() != 0 && r_due[0] <= cyc && $urandom_range(0, 99) < rdy_pct) begin
                rvalid = 1;
                rdata  = pat(r_addr_q[0] + 32'(32 * r_beat));
                rlast  = (r_beat == 127);
                if (n_rlast == rerr_at && r_beat == 0) rresp = 2'b10;
                if (n_rlast == dbad_at && r_beat == 5) rdata[0] = ~rdata[0];
            end
            #1;
            if (rst_n) begin
                check(busy === m_busy, "R7 busy", busy, m_busy);
                check(done === m_done, "R7 done", done, m_done);
                check(err === m_err, "R8 err", err, m_err);
                check(bready && rready, "R12 response ready", {bready, rready}, 2'b11);
                if (start && !m_busy) begin
                    m_base = base_addr & ~32'hFFF;
                    m_num = num_bursts;
                    m_err = 0;
                    m_busy = (num_bursts != 0);
                    m_done = (num_bursts == 0);
                    n_aw = 0; n_ar = 0; n_wbeats = 0; n_wlast = 0; n_b = 0; n_rlast = 0;
                    w_out = 0; r_out = 0; max_w = 0; max_r = 0; w_beat = 0; r_beat = 0;
                    first_aw = 0; last_b = -1; first_ar = 0; last_r = -1;
                end
                if (awvalid && awready) begin
                    check(awaddr == m_base + 32'(n_aw * 4096), "R2/R11 awaddr", awaddr,
                          m_base + 32'(n_aw * 4096));
                    check(awaddr[11:0] == 0 && awlen == 127 && awsize == 5 && awburst == 1,
                          "R2 aw attributes", {awaddr[11:0], awlen, awsize, awburst}, 0);
                    check(n_aw < m_num, "R2 aw count", n_aw, m_num);
                    if (n_aw == 0) first_aw = cyc;
                    n_aw++; w_out++;
                    if (w_out > max_w) max_w = w_out;
                    check(w_out <= 16, "R3 write outstanding", w_out, 16);
                    aw_q.push_back(awaddr);
                end
                if (wvalid && wready) begin
                    if (aw_q.size() == 0) check(0, "R5 data before address", 1, 0);
                    else begin
                        check(wdata == pat(aw_q[0] + 32'(32 * w_beat)), "R5 wdata", wdata,
                              pat(aw_q[0] + 32'(32 * w_beat)));
                        check(wstrb == '1 && wlast == (w_beat == 127), "R5 strb/last",
                              {wstrb, wlast}, {32'hFFFFFFFF, w_beat == 127});
                        n_wbeats++;
                        if (w_beat == 127) begin
                            w_beat = 0;
                            void'(aw_q.pop_front());
                            b_due.push_back(cyc + 1 + lat);
                            b_resp_q.push_back(n_wlast == berr_at ? 2'b10 : 2'b00);
                            n_wlast++;
                        end else w_beat++;
                    end
                end
                if (bvalid && bready) begin
                    if (bresp != 2'b00) m_err = 1;
                    void'(b_due.pop_front());
                    void'(b_resp_q.pop_front());
                    n_b++; w_out--; last_b = cyc;
                end
                if (arvalid && arready) begin
                    check(n_b == m_num, "R4 read before writes done", n_b, m_num);
                    check(araddr == m_base + 32'(n_ar * 4096), "R2/R11 araddr", araddr,
                          m_base + 32'(n_ar * 4096));
                    check(araddr[11:0] == 0 && arlen == 127 && arsize == 5 && arburst == 1,
                          "R2 ar attributes", {araddr[11:0], arlen, arsize, arburst}, 0);
                    if (n_ar == 0) first_ar = cyc;
                    n_ar++; r_out++;
                    if (r_out > max_r) max_r = r_out;
                    check(r_out <= 16, "R3 read outstanding", r_out, 16);
                    r_addr_q.push_back(araddr);
                    r_due.push_back(cyc + 1 + lat);
                end
                if (rvalid && rready) begin
                    if (rresp != 2'b00 || rdata != pat(r_addr_q[0] + 32'(32 * r_beat)))
                        m_err = 1;
                    if (rlast) begin
                        r_beat = 0;
                        void'(r_addr_q.pop_front());
                        void'(r_due.pop_front());
                        n_rlast++; r_out--; last_r = cyc;
                        if (n_rlast == m_num) begin
                            m_busy = 0;
                            m_done = 1;
                        end
                    end else r_beat++;
                end
            end
            cyc++;
        end
    end

    task automatic launch(input logic [31:0] base, input int n);
        @(posedge clk);
        base_addr = base;
        num_bursts = NB_W'(n);
        start_req = 1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run(input string tag, input int n, input bit exp_err);
        int guard = 0;
        while (!done && guard < 60000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        #2;
        check(done === 1'b1, {tag, " R7 run completes"}, done, 1);
        check(n_aw == n && n_ar == n && n_b == n && n_rlast == n,
              {tag, " R2 burst counts"}, {n_aw, n_ar, n_b, n_rlast}, {n, n, n, n});
        check(n_wbeats == n * 128, {tag, " R5 beat total"}, n_wbeats, n * 128);
        check(wr_cycles == CNT_W'(n == 0 ? 0 : last_b - first_aw + 1),
              {tag, " R6 write cycles"}, wr_cycles, n == 0 ? 0 : last_b - first_aw + 1);
        check(rd_cycles == CNT_W'(n == 0 ? 0 : last_r - first_ar + 1),
              {tag, " R6 read cycles"}, rd_cycles, n == 0 ? 0 : last_r - first_ar + 1);
        check(err === exp_err, {tag, " R8/R13 final err"}, err, exp_err);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; base_addr = 0; num_bursts = 0;
        repeat (3) @(negedge clk);
        #2;
        check(!busy && !done && !err && !awvalid && !wvalid && !arvalid,
              "R1 outputs in reset", {busy, done, err, awvalid, wvalid, arvalid}, 0);
        check(wr_cycles == 0 && rd_cycles == 0, "R1 counts in reset",
              {wr_cycles, rd_cycles}, 0);
        @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        #2;
        check(!busy && !done && !awvalid && !arvalid, "R1 idle after reset",
              {busy, done, awvalid, arvalid}, 0);

        // Short clean run, no stalls.
        rdy_pct = 100; lat = 2;
        launch(32'h1000_0000, 3);
        finish_run("basic", 3, 0);

        // Long stalled run: the in-flight window must fill to its limit.
        rdy_pct = 50; lat = 40;
        launch(32'h2000_0000, 20);
        finish_run("stalled", 20, 0);
        check(max_w == 16, "R3 write window reached", max_w, 16);
        check(max_r == 16, "R3 read window reached", max_r, 16);

        // Unaligned base rounds down to 4 KiB.
        rdy_pct = 80; lat = 5;
        launch(32'h3000_0ABC, 2);
        finish_run("unaligned R11", 2, 0);

        // Write error response.
        berr_at = 1;
        launch(32'h4000_0000, 4);
        finish_run("bresp R8", 4, 1);
        berr_at = -1;

        // Read error response.
        rerr_at = 2;
        launch(32'h5000_0000, 4);
        finish_run("rresp R8", 4, 1);
        rerr_at = -1;

        // Corrupted read data.
        dbad_at = 0;
        launch(32'h6000_0000, 3);
        finish_run("rdata R13", 3, 1);
        dbad_at = -1;

        // A clean run after an error clears the flag.
        launch(32'h7000_0000, 2);
        finish_run("clear R8", 2, 0);

        // Start while busy is ignored.
        rdy_pct = 70; lat = 10;
        launch(32'h0800_0000, 6);
        repeat (60) @(negedge clk);
        check(busy === 1'b1, "R9 still busy before second start", busy, 1);
        launch(32'h0900_0000, 2);
        finish_run("busy start R9", 6, 0);

        // Empty run.
        launch(32'h0A00_0000, 0);
        finish_run("empty R10", 0, 0);
        check(n_aw == 0 && !busy, "R10 no requests", {n_aw, busy}, 0);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule